// File: doc/BRIEF.md
# Host Controller Interrupt Mask Pair

This block holds the interrupt masking state of a host controller. A single enable register is reached at two bus addresses. A write to the set view turns on every enable bit that carries a 1 in the write data. A write to the clear view turns off every enable bit that carries a 1. At either view, a 0 in the write data leaves the matching bit as it was. Both views read back the same live enable value.

A companion status register latches eight interrupt sources. Seven of them are controller events and one is an ownership change. Software clears a status bit by writing 1 to it. One enable bit acts as a master gate. The block drives a single registered interrupt request. The request is high when the master gate is on and at least one latched source is also enabled.

Software reaches the block through a simple synchronous bus with a byte address, a write strobe, 32-bit write data and combinational 32-bit read data. The event inputs are single-cycle pulses from the controller's event logic.

Top module: `hc_irq_mask`

## Requirements
- R1: After reset, the status view, the set view and the clear view all read 0, and `irq_o` is 0.
- R2: A write to the set view (offset 0x04) sets every implemented enable bit whose write-data bit is 1. Write-data bits that are 0 leave their enable bits unchanged.
- R3: A write to the clear view (offset 0x08) clears every enable bit whose write-data bit is 1. Write-data bits that are 0 leave their enable bits unchanged.
- R4: Reads of the set view and of the clear view both return the current enable value.
- R5: Bits 29 to 7 are reserved in both registers. They read as 0 through every view, and writes to them have no effect.
- R6: A pulse on `evt_i[i]` sets status bit i (i = 0..6), and a pulse on `own_chg_i` sets status bit 30. A set status bit stays set until software clears it. Bit 31 of the status view reads 0.
- R7: A write to the status view (offset 0x00) clears every status bit whose write-data bit is 1. Write-data bits that are 0 have no effect.
- R8: If an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o` is a register. It is 1 one cycle after enable bit 31 is 1 and some status bit in {30, 6..0} is 1 together with its enable bit.
- R10: While enable bit 31 (the master gate) is 0, `irq_o` stays 0 whatever the status and enable bits hold.
- R11: A write to any other offset changes neither register. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_i | input | 7 | Event pulses, bit i feeds status bit i |
| own_chg_i | input | 1 | Ownership-change event pulse, feeds status bit 30 |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters. These are a 32-bit data path, seven low event sources, the ownership-change bit at 30, the master gate at 31 and view offsets 0x00, 0x04 and 0x08. With these values every reserved bit between the two groups can be reached, so all-ones writes show the reserved field staying at zero. Because the sources split into a low group and a lone high bit, the bench can separate the low group from the ownership-change path both when latching events and when raising the interrupt. The bench also lines up an event pulse with a clear of the same status bit, and times the one-cycle lag of the interrupt request.

// File: rtl/irqm_pkg.sv
// Package irqm_pkg
// Holds the types shared by the interrupt mask block: which register view
// a bus access selects.
package irqm_pkg;

    typedef enum logic [1:0] {
        VIEW_NONE   = 2'd0,
        VIEW_STATUS = 2'd1,
        VIEW_SET    = 2'd2,
        VIEW_CLR    = 2'd3
    } view_e;

endpackage

// File: rtl/irqm_decode.sv
// Module irqm_decode
// Turns a bus address and write strobe into a view selection and per-view
// write vectors. It assumes one access per cycle and that offsets are distinct.
module irqm_decode
    import irqm_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int OFS_STATUS = 0,
    parameter int OFS_SET    = 4,
    parameter int OFS_CLR    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output view_e             view,
    output logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] ack_vec
);

    // Map the address onto one of the register views.
    always_comb begin
        if (addr == ADDR_W'(OFS_STATUS))      view = VIEW_STATUS;
        else if (addr == ADDR_W'(OFS_SET))    view = VIEW_SET;
        else if (addr == ADDR_W'(OFS_CLR))    view = VIEW_CLR;
        else                                  view = VIEW_NONE;
    end

    // Route the write data to the vector of the addressed view.
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        ack_vec = '0;
        if (wr) begin
            case (view)
                VIEW_SET:    set_vec = wdata;
                VIEW_CLR:    clr_vec = wdata;
                VIEW_STATUS: ack_vec = wdata;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/irqm_enable_reg.sv
// Module irqm_enable_reg
// The enable register. Set and clear vectors act only on the 1s they carry,
// and clear wins when both hit the same bit. Bits outside IMPL_MASK stay 0.
module irqm_enable_reg #(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec,
    input  logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] en_q
);

    // One flop per implemented bit, constant 0 for reserved bits.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            // Update the enable bit; clear has priority over set.
            always_ff @(posedge clk) begin
                if (!rst_n)          en_q[b] <= 1'b0;
                else if (clr_vec[b]) en_q[b] <= 1'b0;
                else if (set_vec[b]) en_q[b] <= 1'b1;
            end
        end else begin : g_rsv
            assign en_q[b] = 1'b0;
        end
    end

endmodule

// File: rtl/irqm_status_reg.sv
// Module irqm_status_reg
// Sticky status bits. An event pulse sets a bit, a write-one acknowledge
// clears it, and the event wins on a tie. Bits outside SRC_MASK stay 0.
module irqm_status_reg #(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] SRC_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_vec,
    input  logic [DATA_W-1:0] ack_vec,
    output logic [DATA_W-1:0] st_q
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (SRC_MASK[b]) begin : g_src
            // Latch the event; an acknowledge only clears when no event arrives.
            always_ff @(posedge clk) begin
                if (!rst_n)          st_q[b] <= 1'b0;
                else if (evt_vec[b]) st_q[b] <= 1'b1;
                else if (ack_vec[b]) st_q[b] <= 1'b0;
            end
        end else begin : g_rsv
            assign st_q[b] = 1'b0;
        end
    end

endmodule

// File: rtl/irqm_irq_gen.sv
// Module irqm_irq_gen
// Registered interrupt request: the master bit gates the OR of the enabled
// status bits. It assumes both inputs come straight from flops.
module irqm_irq_gen #(
    parameter int                DATA_W     = 32,
    parameter int                MASTER_BIT = 31,
    parameter logic [DATA_W-1:0] SRC_MASK   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] st_q,
    input  logic [DATA_W-1:0] en_q,
    output logic              irq_o
);

    logic any_src;

    // Find any source that is both latched and enabled.
    always_comb any_src = |(st_q & en_q & SRC_MASK);

    // Register the gated request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= en_q[MASTER_BIT] & any_src;
    end

endmodule

// File: rtl/hc_irq_mask.sv
// Module hc_irq_mask
// Interrupt enable register reached through a set view and a clear view,
// plus a sticky status register and a registered interrupt request.
// It assumes event inputs are synchronous one-cycle pulses.
module hc_irq_mask
    import irqm_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int NUM_LOW    = 7,
    parameter int OWN_BIT    = 30,
    parameter int MASTER_BIT = 31,
    parameter int OFS_STATUS = 0,
    parameter int OFS_SET    = 4,
    parameter int OFS_CLR    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_LOW-1:0] evt_i,
    input  logic              own_chg_i,
    output logic              irq_o
);

    localparam logic [DATA_W-1:0] ONE_W       = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] LOW_MASK    = (ONE_W << NUM_LOW) - ONE_W;
    localparam logic [DATA_W-1:0] OWN_MASK    = ONE_W << OWN_BIT;
    localparam logic [DATA_W-1:0] MASTER_MASK = ONE_W << MASTER_BIT;
    localparam logic [DATA_W-1:0] SRC_MASK    = LOW_MASK | OWN_MASK;
    localparam logic [DATA_W-1:0] IMPL_MASK   = SRC_MASK | MASTER_MASK;

    view_e             view;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] ack_vec;
    logic [DATA_W-1:0] evt_vec;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] st_q;

    irqm_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFS_STATUS(OFS_STATUS), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR)
    ) u_dec (
        .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .view(view), .set_vec(set_vec), .clr_vec(clr_vec), .ack_vec(ack_vec)
    );

    irqm_enable_reg #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_en (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .en_q(en_q)
    );

    // Spread the event pulses over their status bit positions.
    always_comb begin
        evt_vec = {{(DATA_W-NUM_LOW){1'b0}}, evt_i};
        if (own_chg_i) evt_vec = evt_vec | OWN_MASK;
    end

    irqm_status_reg #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK)) u_st (
        .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .ack_vec(ack_vec), .st_q(st_q)
    );

    irqm_irq_gen #(.DATA_W(DATA_W), .MASTER_BIT(MASTER_BIT), .SRC_MASK(SRC_MASK)) u_irq (
        .clk(clk), .rst_n(rst_n), .st_q(st_q), .en_q(en_q), .irq_o(irq_o)
    );

    // Read mux: both enable views return the same live enable value.
    always_comb begin
        case (view)
            VIEW_STATUS:       bus_rdata = st_q & SRC_MASK;
            VIEW_SET, VIEW_CLR: bus_rdata = en_q & IMPL_MASK;
            default:           bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqm_checker.sv
// Module irqm_checker
// Temporal checks on hc_irq_mask, attached with a bind below.
module irqm_checker #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int NUM_LOW    = 7,
    parameter int OWN_BIT    = 30,
    parameter int MASTER_BIT = 31,
    parameter int OFS_SET    = 4,
    parameter int OFS_CLR    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_LOW-1:0] evt_i,
    input logic              own_chg_i,
    input logic              irq_o,
    input logic [DATA_W-1:0] en_q,
    input logic [DATA_W-1:0] st_q
);

    localparam logic [DATA_W-1:0] ONE_W    = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] SRC_MASK = ((ONE_W << NUM_LOW) - ONE_W) | (ONE_W << OWN_BIT);
    localparam logic [DATA_W-1:0] IMPL     = SRC_MASK | (ONE_W << MASTER_BIT);

    logic [DATA_W-1:0] ev;
    always_comb ev = {{(DATA_W-NUM_LOW){1'b0}}, evt_i} | (own_chg_i ? (ONE_W << OWN_BIT) : '0);

    AST_SET_VIEW_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_SET)) |=> ((en_q & $past(bus_wdata) & IMPL) == ($past(bus_wdata) & IMPL))); // R2
    AST_CLR_VIEW_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR)) |=> ((en_q & $past(bus_wdata)) == '0)); // R3
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_SET) || bus_addr == ADDR_W'(OFS_CLR)) |-> ((bus_rdata & ~IMPL) == '0)); // R5
    AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((st_q & $past(ev)) == $past(ev))); // R6
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(st_q & en_q & SRC_MASK))); // R9
    AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_q[MASTER_BIT])); // R10

endmodule

bind hc_irq_mask irqm_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LOW(NUM_LOW), .OWN_BIT(OWN_BIT),
    .MASTER_BIT(MASTER_BIT), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .own_chg_i(own_chg_i), .irq_o(irq_o), .en_q(en_q), .st_q(st_q)
);

// File: tb/sim_hc_irq_mask.sv
module sim_hc_irq_mask;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_ST  = 8'h00;
    localparam logic [7:0] A_SET = 8'h04;
    localparam logic [7:0] A_CLR = 8'h08;
    localparam logic [7:0] A_BAD = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  evt_i = '0;
    logic        own_chg_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hc_irq_mask u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
        .own_chg_i(own_chg_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [6:0] e, input logic oc);
        @(negedge clk);
        evt_i = e; own_chg_i = oc;
        @(negedge clk);
        evt_i = '0; own_chg_i = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_ST, v);  check("R1 status", v, 32'h0);
        rd(A_SET, v); check("R1 set view", v, 32'h0);
        rd(A_CLR, v); check("R1 clear view", v, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_set_view;
        logic [31:0] v;
        wr(A_SET, 32'h0000_0005);
        rd(A_SET, v); check("R2 set ones", v, 32'h0000_0005);
        wr(A_SET, 32'h0000_0002);
        rd(A_SET, v); check("R2 zeros ignored", v, 32'h0000_0007);
        rd(A_CLR, v); check("R4 clear view reads enable", v, 32'h0000_0007);
    endtask

    task automatic t_clr_view;
        logic [31:0] v;
        wr(A_CLR, 32'h0000_0001);
        rd(A_CLR, v); check("R3 clear ones", v, 32'h0000_0006);
        wr(A_CLR, 32'h0000_0000);
        rd(A_SET, v); check("R3 zeros ignored", v, 32'h0000_0006);
        check("R4 set view matches", v, 32'h0000_0006);
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        wr(A_SET, 32'hFFFF_FFFF);
        rd(A_SET, v); check("R5 set view reserved", v, 32'hC000_007F);
        rd(A_CLR, v); check("R5 clear view reserved", v, 32'hC000_007F);
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_SET, v); check("R5 cleared all", v, 32'h0);
    endtask

    task automatic t_events;
        logic [31:0] v;
        pulse(7'h12, 1'b0);
        rd(A_ST, v); check("R6 low events", v, 32'h0000_0012);
        pulse(7'h00, 1'b1);
        repeat (3) @(negedge clk);
        rd(A_ST, v); check("R6 ownership sticky", v, 32'h4000_0012);
        pulse(7'h7F, 1'b1);
        rd(A_ST, v); check("R6 all sources, bit31 zero", v, 32'h4000_007F);
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v); check("R7 clear all", v, 32'h0);
        pulse(7'h12, 1'b1);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(A_ST, 32'h0000_0002);
        rd(A_ST, v); check("R7 write one clears", v, 32'h4000_0010);
        wr(A_ST, 32'h0000_0000);
        rd(A_ST, v); check("R7 zeros ignored", v, 32'h4000_0010);
    endtask

    task automatic t_evt_wins;
        logic [31:0] v;
        pulse(7'h0C, 1'b0);
        @(negedge clk);
        bus_addr = A_ST; bus_wdata = 32'h0000_000C; bus_wr = 1'b1; evt_i = 7'h04;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; evt_i = '0;
        rd(A_ST, v); check("R8 event beats clear", v, 32'h4000_0014);
        wr(A_ST, 32'h0000_0004);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(A_SET, 32'h0000_0010);
        @(negedge clk);
        check("R10 no master", {31'b0, irq_o}, 32'h0);
        wr(A_SET, 32'h8000_0000);
        check("R9 one cycle lag", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq raised", {31'b0, irq_o}, 32'h1);
        wr(A_ST, 32'h0000_0010);
        @(negedge clk);
        check("R9 irq drops after ack", {31'b0, irq_o}, 32'h0);
        wr(A_SET, 32'h4000_0000);
        @(negedge clk);
        check("R9 ownership source", {31'b0, irq_o}, 32'h1);
        wr(A_CLR, 32'h8000_0000);
        @(negedge clk);
        check("R10 master off blocks", {31'b0, irq_o}, 32'h0);
        rd(A_ST, v); check("R10 status kept", v, 32'h4000_0000);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_BAD, v); check("R11 unmapped reads 0", v, 32'h0);
        rd(A_SET, v); check("R11 enable untouched", v, 32'h4000_0010);
        rd(A_ST, v);  check("R11 status untouched", v, 32'h4000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_view();
        t_clr_view();
        t_reserved();
        t_events();
        t_w1c();
        t_evt_wins();
        t_irq();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule